// File: doc/BRIEF.md
# I2C Register Target with CRC-8 Protection

This block is an I2C target that gives a bus controller read and write access to a byte-addressed register file beside it. The controller first addresses the target, then sends one byte that sets an internal register pointer. Any bytes that follow are written at the pointer. A read fetches bytes from the pointer. The read phase may follow the write phase after a repeated start, or after a stop and a new start. The pointer advances by one after every data byte, in either direction, so a block transfer needs only one register address.

When `crc_en` is high, every data byte carries a CRC-8 byte. The generator polynomial is 0x07 and the accumulator starts at zero. For the first data byte after the pointer is set, the CRC covers the address phase as well. For later bytes it covers that data byte alone. The accumulator is cleared after each data byte and at every stop. A written byte reaches the register file only after its CRC byte has been checked. A mismatch is refused with a NACK and drops the target back to idle. The bus pins are open-drain: the target only ever pulls SDA low, and it never holds SCL.

Top module: `i2c_crc_regtarget`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `dev_addr`; bit 0 is the direction (0 write, 1 read). On any other address it sends no ACK and ignores the bus until the next start.
- R2: In a write, the byte after the address sets the register pointer. Each data byte is written at the pointer with a one-cycle `reg_we` pulse, and the pointer then increments, so `reg_addr` ends one past the last byte written.
- R3: With `crc_en` low, no CRC byte is expected. Each write data byte is committed in the same bus bit in which it is ACKed.
- R4: With `crc_en` high, each write data byte is followed by a CRC-8 byte (polynomial 0x07, initial value 0x00, MSB first). For the first data byte the CRC spans the write-address byte, the register byte and the data byte; for later bytes it spans only that data byte. The data byte is committed only when its CRC matches.
- R5: On a write CRC mismatch, the target NACKs the CRC byte, writes nothing, and NACKs further bytes until a new start.
- R6: In a read, the target returns the byte at the pointer, MSB first, and increments the pointer after each data byte.
- R7: In a read with CRC enabled after a repeated start, the first CRC spans the write-address byte, the register byte, the read-address byte and the data byte. Each later CRC spans only its data byte.
- R8: A read that follows a stop and a new start returns data from the pointer set by the earlier write phase. Its first CRC spans the read-address byte and the data byte, because the stop cleared the accumulator.
- R9: During a read, the target keeps sending bytes (data and CRC pairs when CRC is on) while the controller ACKs. After a NACK it releases SDA and drives nothing more until the next start.
- R10: `sda_oe` = 1 pulls SDA low. `sda_oe` changes only while SCL is low.
- R11: After reset, `sda_oe` = 0, `reg_we` = 0 and `reg_addr` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_addr | input | 7 | Target's 7-bit bus address |
| crc_en | input | 1 | Enables the CRC byte after each data byte |
| reg_addr | output | 8 | Register pointer, addresses the register file |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register file read data at `reg_addr` |

## Verification
A fault in the bit counter or the state register appears at the ports within one byte. An ACK lands in the wrong bit, or a read byte comes back shifted. The bench samples both on every bit of the bus. A wrong CRC accumulator is visible at the end of the byte it corrupts: a correct CRC byte is NACKed, or the CRC byte sent in a read does not match. A wrong pointer shows as a `reg_we` pulse with an unexpected address, compared on the clock it occurs, or as data read back from the wrong location.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_WCRC,
    ST_RDATA,
    ST_RCRC
  } tgt_state_e;

  // One byte through a CRC-8 register, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] seed,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
    logic [7:0] r;
    logic       fb;
    r = seed;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ data[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  // SDA edges while SCL stays high mark start and stop.
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_crc8_acc.sv
module i2c_crc8_acc
  import i2c_tgt_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] acc
);

  logic [7:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr)      acc_d = 8'h00;
    else if (upd) acc_d = crc8_step(acc_q, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 8'h00;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R4: the accumulator only moves when told to.
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!clr && !upd) |-> (acc_q == $past(acc_q)));

endmodule

// File: rtl/i2c_crc_regtarget.sv
module i2c_crc_regtarget
  import i2c_tgt_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CRC_POLY    = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [6:0] dev_addr,
  input  logic       crc_en,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  localparam logic [3:0] BIT_LAST = 4'd8;  // falling edge ending the byte
  localparam logic [3:0] ACK_LAST = 4'd9;  // falling edge ending the ack slot

  // Reset release synchronised to clk.
  logic [1:0] rst_pipe;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tgt_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] rxsh_q, rxsh_d;
  logic [7:0] txb_q, txb_d;
  logic [7:0] ptr_q, ptr_d;
  logic [7:0] pend_q, pend_d;
  logic [7:0] wd_q, wd_d;
  logic       oe_q, oe_d;
  logic       mack_q, mack_d;
  logic       we_q, we_d;

  logic       crc_clr, crc_upd;
  logic [7:0] crc_din, crc_val;
  logic [7:0] tx_shifted;
  logic       tx_phase;

  i2c_crc8_acc #(.POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_int),
    .clr   (crc_clr),
    .upd   (crc_upd),
    .din   (crc_din),
    .acc   (crc_val)
  );

  assign tx_phase   = (state_q == ST_RDATA) || (state_q == ST_RCRC);
  assign tx_shifted = txb_q << cnt_q[2:0];

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rxsh_d  = rxsh_q;
    txb_d   = txb_q;
    ptr_d   = ptr_q;
    pend_d  = pend_q;
    wd_d    = wd_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    we_d    = 1'b0;
    crc_clr = 1'b0;
    crc_upd = 1'b0;
    crc_din = rxsh_q;

    // Pointer steps in the cycle the write strobe is out.
    if (we_q) ptr_d = ptr_q + 8'd1;

    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      crc_clr = 1'b1;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = 4'd0;
      oe_d    = 1'b0;
    end else if (scl_rise && state_q != ST_IDLE) begin
      if (cnt_q < BIT_LAST)       rxsh_d = {rxsh_q[6:0], sda_lvl};
      else if (cnt_q == BIT_LAST) mack_d = ~sda_lvl;
      if (cnt_q != ACK_LAST)      cnt_d  = cnt_q + 4'd1;
    end else if (scl_fall && state_q != ST_IDLE) begin
      if (cnt_q >= 4'd1 && cnt_q < BIT_LAST) begin
        if (tx_phase) oe_d = ~tx_shifted[7];
      end else if (cnt_q == BIT_LAST) begin
        // Byte complete: drive the ack, or release for the controller's ack.
        case (state_q)
          ST_ADDR: begin
            if (rxsh_q[7:1] == dev_addr) begin
              oe_d    = 1'b1;
              crc_upd = 1'b1;
            end
          end
          ST_REG: begin
            oe_d    = 1'b1;
            crc_upd = 1'b1;
            ptr_d   = rxsh_q;
          end
          ST_WDATA: begin
            oe_d = 1'b1;
            if (crc_en) begin
              crc_upd = 1'b1;
              pend_d  = rxsh_q;
            end else begin
              crc_clr = 1'b1;
              we_d    = 1'b1;
              wd_d    = rxsh_q;
            end
          end
          ST_WCRC: begin
            crc_clr = 1'b1;
            if (rxsh_q == crc_val) begin
              oe_d = 1'b1;
              we_d = 1'b1;
              wd_d = pend_q;
            end
          end
          ST_RDATA: begin
            oe_d    = 1'b0;
            crc_din = txb_q;
            crc_upd = 1'b1;
            ptr_d   = ptr_q + 8'd1;
          end
          ST_RCRC: begin
            oe_d    = 1'b0;
            crc_clr = 1'b1;
          end
          default: oe_d = 1'b0;
        endcase
      end else if (cnt_q == ACK_LAST) begin
        cnt_d = 4'd0;
        oe_d  = 1'b0;
        case (state_q)
          ST_ADDR: begin
            if (!oe_q) begin
              state_d = ST_IDLE;
              crc_clr = 1'b1;
            end else if (rxsh_q[0]) begin
              state_d = ST_RDATA;
              txb_d   = reg_rdata;
              oe_d    = ~reg_rdata[7];
            end else begin
              state_d = ST_REG;
            end
          end
          ST_REG:   state_d = ST_WDATA;
          ST_WDATA: state_d = crc_en ? ST_WCRC : ST_WDATA;
          ST_WCRC: begin
            if (oe_q) state_d = ST_WDATA;
            else begin
              state_d = ST_IDLE;
              crc_clr = 1'b1;
            end
          end
          ST_RDATA: begin
            if (!mack_q) begin
              state_d = ST_IDLE;
              crc_clr = 1'b1;
            end else if (crc_en) begin
              state_d = ST_RCRC;
              txb_d   = crc_val;
              oe_d    = ~crc_val[7];
            end else begin
              txb_d = reg_rdata;
              oe_d  = ~reg_rdata[7];
            end
          end
          ST_RCRC: begin
            if (!mack_q) begin
              state_d = ST_IDLE;
              crc_clr = 1'b1;
            end else begin
              state_d = ST_RDATA;
              txb_d   = reg_rdata;
              oe_d    = ~reg_rdata[7];
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      rxsh_q  <= 8'h00;
      txb_q   <= 8'h00;
      ptr_q   <= 8'h00;
      pend_q  <= 8'h00;
      wd_q    <= 8'h00;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rxsh_q  <= rxsh_d;
      txb_q   <= txb_d;
      ptr_q   <= ptr_d;
      pend_q  <= pend_d;
      wd_q    <= wd_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
      we_q    <= we_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wd_q;
  assign reg_we    = we_q;

  // R10: the line drive moves only while the synchronised SCL is low.
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_int)
    (oe_q != $past(oe_q)) |-> !$past(scl_lvl));

  // R2: the write strobe is a single-cycle pulse.
  a_r2_we_pulse: assert property (@(posedge clk) disable iff (!rst_int)
    we_q |=> !we_q);

  // R2: the pointer steps by one after each write.
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_int)
    we_q |=> (ptr_q == $past(ptr_q) + 8'd1));

  // R3: a byte is committed only together with the ack the target drives.
  a_r3_we_acked: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(we_q) |-> oe_q);

  // R5: nothing is driven onto SDA while idle.
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int)
    (state_q == ST_IDLE) |-> !oe_q);

endmodule

// File: tb/i2c_crc_regtarget_tb.sv
module i2c_crc_regtarget_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HP         = 8;
  localparam logic [7:0] DEVW = 8'h10;
  localparam logic [7:0] DEVR = 8'h11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_oe, sda_bus;
  logic       crc_en;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_crc_regtarget u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .dev_addr  (7'h08),
    .crc_en    (crc_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  // Register file beside the target
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  // Reference model: expected register contents and expected write strobes
  logic [7:0]  model [256];
  logic [15:0] wq [$];
  int vecs = 0;
  int errs = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  // Per-clock comparison against the model
  logic oe_prev, scl_prev;
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (wq.size() == 0) chk("R5 unexpected write strobe", {reg_addr, reg_wdata}, 0);
        else chk("R2 write strobe addr/data", {reg_addr, reg_wdata}, wq.pop_front());
      end
      if (scl_prev && scl_m && (sda_oe != oe_prev))
        chk("R10 sda_oe moved while SCL high", sda_oe, oe_prev);
    end
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(HP);
    scl_m = 1'b1; wt(HP);
    sda_m = 1'b0; wt(HP);
    scl_m = 1'b0; wt(HP);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(HP);
    scl_m = 1'b1; wt(HP);
    sda_m = 1'b1; wt(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HP);
      scl_m = 1'b1; wt(HP);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(HP);
    scl_m = 1'b1; wt(HP/2);
    ack = ~sda_bus; wt(HP/2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HP);
      scl_m = 1'b1; wt(HP/2);
      b[i] = sda_bus; wt(HP/2);
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wt(HP);
    scl_m = 1'b1; wt(HP);
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] ra, input logic [7:0] d0, input logic [7:0] d1,
                          input int n, input logic corrupt, input string tag);
    logic       a;
    logic [7:0] c, d;
    bus_start();
    send_byte(DEVW, a); chk({tag, " addr ack"}, a, 1);
    send_byte(ra, a);   chk({tag, " reg ack"}, a, 1);
    c = crc_b(8'h00, DEVW);
    c = crc_b(c, ra);
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : d1;
      if (!crc_en) begin
        wq.push_back({ra + 8'(k), d});
        model[ra + 8'(k)] = d;
      end
      send_byte(d, a); chk({tag, " data ack"}, a, 1);
      if (crc_en) begin
        c = crc_b(c, d);
        if (!corrupt) begin
          wq.push_back({ra + 8'(k), d});
          model[ra + 8'(k)] = d;
        end
        send_byte(corrupt ? (c ^ 8'h01) : c, a);
        chk({tag, " crc ack"}, a, corrupt ? 0 : 1);
        c = 8'h00;
        if (corrupt) begin
          send_byte(8'h99, a);
          chk("R5 byte after bad crc ignored", a, 0);
          break;
        end
      end
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] ra, input int n, input logic rep, input string tag);
    logic       a;
    logic [7:0] c, d, cb;
    bus_start();
    send_byte(DEVW, a); chk({tag, " addr ack"}, a, 1);
    send_byte(ra, a);   chk({tag, " reg ack"}, a, 1);
    c = crc_b(8'h00, DEVW);
    c = crc_b(c, ra);
    if (!rep) begin
      bus_stop();
      c = 8'h00;
    end
    bus_start();
    send_byte(DEVR, a); chk({tag, " read addr ack"}, a, 1);
    c = crc_b(c, DEVR);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, crc_en ? 1'b1 : (k != n - 1));
      chk({tag, " data"}, d, model[ra + 8'(k)]);
      if (crc_en) begin
        c = crc_b(c, d);
        recv_byte(cb, k != n - 1);
        chk({tag, " crc"}, cb, c);
        c = 8'h00;
      end
    end
    wt(4);
    chk("R9 released after nack", sda_oe, 0);
    chk("R6 pointer after read", reg_addr, 32'(ra + 8'(n)));
    bus_stop();
  endtask

  initial begin
    logic       a;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
    scl_m = 1'b1; sda_m = 1'b1; crc_en = 1'b0;
    oe_prev = 1'b0; scl_prev = 1'b1;
    rst_n = 1'b0;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    chk("R11 sda_oe after reset", sda_oe, 0);
    chk("R11 reg_we after reset", reg_we, 0);
    chk("R11 reg_addr after reset", reg_addr, 0);

    // R1: a foreign address gets no ack and the target stays off the bus
    bus_start();
    send_byte(8'h22, a); chk("R1 foreign address nack", a, 0);
    send_byte(8'h05, a); chk("R1 ignored until next start", a, 0);
    bus_stop();
    send_byte(8'h10, a); chk("R1 no start, no ack", a, 0);
    bus_stop();

    // R3/R2: plain block write, then pointer position
    do_write(8'h05, 8'hA1, 8'hB2, 2, 1'b0, "R3 plain write");
    wt(4);
    chk("R2 pointer after block write", reg_addr, 8'h07);

    // R6: block read with repeated start
    do_read(8'h05, 3, 1'b1, "R6 plain read");

    // R4: protected block write
    crc_en = 1'b1;
    do_write(8'h40, 8'h3C, 8'hC3, 2, 1'b0, "R4 crc write");

    // R7: protected read with repeated start
    do_read(8'h40, 2, 1'b1, "R7 crc read");

    // R8: protected read after stop and new start
    do_read(8'h05, 2, 1'b0, "R8 split read");

    // R5: corrupted CRC
    do_write(8'h10, 8'h77, 8'h00, 1, 1'b1, "R5 bad crc write");
    crc_en = 1'b0;
    do_read(8'h10, 1, 1'b1, "R5 location unchanged");

    // R9: controller NACKs the first data byte with CRC on, target goes quiet
    crc_en = 1'b1;
    bus_start();
    send_byte(DEVW, a);
    send_byte(8'h40, a);
    bus_start();
    send_byte(DEVR, a);
    recv_byte(d, 1'b0);
    chk("R9 data before nack", d, model[8'h40]);
    recv_byte(d, 1'b0);
    chk("R9 no crc after nack", d, 8'hFF);
    bus_stop();

    wt(20);
    chk("R2 all expected writes seen", wq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired, R1 to R11 incomplete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule